// File: doc/BRIEF.md
# Cascadable Programmable 4-Bit Counter

This block is a small synchronous up-counter meant to be dropped into control paths, timers and frequency dividers. Its state advances on the rising clock edge when two active-high count enables are both high. An active-low synchronous load copies a preset word into the state. An active-low clear zeroes the state. A parameter chooses whether the clear acts at once or waits for the next rising edge. A second parameter chooses between modulo-16 and modulo-10 counting.

A combinational carry output goes high while the counter sits on its terminal value and the second count enable (the "trickle" enable) is high. Wider synchronous counters are built by wiring each stage's carry into the next stage's trickle enable, with one shared clock and no extra gating. The first enable (the "parallel" enable) of every stage is tied to a common run signal.

When several controls are active together, clear wins over load, load wins over counting, and counting wins over holding.

Top module: `progctr4`

## Requirements
- R1: With ASYNC_CLR=1, a low on `clr_n` forces `q` to 0 at once, without waiting for a clock edge.
- R2: With ASYNC_CLR=0, a low on `clr_n` leaves `q` unchanged until the next rising edge, and `q` is 0 after that edge.
- R3: While `clr_n` is low, `q` ends at 0 after a rising edge even when `ld_n` is low and both enables are high.
- R4: With `clr_n` high and `ld_n` low, `q` equals `preset` after the next rising edge, whatever the values of `en_p` and `en_t`.
- R5: With `clr_n` and `ld_n` high, `q` goes up by one at a rising edge only when `en_p` and `en_t` are both high. Otherwise `q` holds its value.
- R6: With DECADE=0, counting from 15 gives 0.
- R7: With DECADE=1, counting from 9 gives 0.
- R8: With DECADE=1, a loaded value from 10 to 15 counts up by one per edge to 15 and then to 0. `carry` stays low on all of those values.
- R9: `carry` is high exactly when `en_t` is high and `q` equals the terminal value (15 when DECADE=0, 9 when DECADE=1). It follows `en_t` without a clock edge.
- R10: Stages that share the clock and `en_p`, where each stage's `en_t` is driven by the previous stage's `carry`, count together as one wider binary counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. The state changes on the rising edge. |
| clr_n | input | 1 | Active-low clear. Acts at once or at the next edge, depending on ASYNC_CLR. |
| ld_n | input | 1 | Active-low synchronous load of `preset`. |
| preset | input | 4 | Word loaded into the counter. |
| en_p | input | 1 | Parallel count enable. Active high. |
| en_t | input | 1 | Trickle count enable. Active high. Also gates `carry`. |
| q | output | 4 | Counter state. |
| carry | output | 1 | Terminal-count carry, gated by `en_t`. |

## Verification
The bench drops clear in the middle of a clock cycle. An asynchronous-clear design that waited for an edge would still show the old count at that point, and a synchronous-clear design that reacted at once would already show zero. It holds load and both enables active during clear, and it loads with the enables high. A wrong priority order would show up there as the preset value, or as the preset value plus one.

The bench runs each enable high on its own, to catch a design that counts on an OR of the enables. It loads 12 into the decade counter and counts up, to catch early wraps and false carries at 10 to 15. It toggles `en_t` while the counter sits on its terminal value, to catch a carry that ignores that enable. It also counts a three-stage chain through 0xFFF. A stage that passed carry on one cycle late, or that ignored `en_t`, would skip or repeat counts in the upper digits.

// File: rtl/progctr_pkg.sv
// Package: shared types and helpers for the programmable counter.
// Assumes: widths of 4 or more when decade counting is selected.
package progctr_pkg;

    // Operation chosen for the next rising edge, in priority order.
    typedef enum logic [1:0] {
        OP_CLEAR = 2'd0,
        OP_LOAD  = 2'd1,
        OP_COUNT = 2'd2,
        OP_HOLD  = 2'd3
    } ctr_op_e;

    // Terminal value of the count sequence for a given width and modulus.
    function automatic int term_value(input int width, input bit decade);
        return decade ? 9 : ((1 << width) - 1);
    endfunction

endpackage

// File: rtl/progctr_ctl.sv
// Module: progctr_ctl
// Picks the operation for the next clock edge from the control inputs.
// Priority is clear, then load, then count, then hold.
// Assumes: all inputs are active-low where named *_n; the enables are active high.
module progctr_ctl
    import progctr_pkg::*;
(
    input  logic    clr_n,
    input  logic    ld_n,
    input  logic    en_p,
    input  logic    en_t,
    output ctr_op_e op
);

    // Priority decode of the controls.
    always_comb begin
        if (!clr_n)
            op = OP_CLEAR;
        else if (!ld_n)
            op = OP_LOAD;
        else if (en_p && en_t)
            op = OP_COUNT;
        else
            op = OP_HOLD;
    end

endmodule

// File: rtl/progctr_next.sv
// Module: progctr_next
// Next-state logic: clears, loads, increments with wrap, or holds.
// Assumes: values above the terminal value (decade mode only) count up and
// wrap at the natural overflow of the register.
module progctr_next
    import progctr_pkg::*;
#(
    parameter int WIDTH  = 4,
    parameter bit DECADE = 1'b0
) (
    input  ctr_op_e          op,
    input  logic [WIDTH-1:0] q,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] d
);

    localparam logic [WIDTH-1:0] TERM = WIDTH'(term_value(WIDTH, DECADE));

    logic [WIDTH-1:0] incr;

    // Increment with wrap at the terminal value.
    always_comb begin
        if (q == TERM)
            incr = '0;
        else
            incr = q + WIDTH'(1);
    end

    // Select the next state from the decoded operation.
    always_comb begin
        unique case (op)
            OP_CLEAR: d = '0;
            OP_LOAD:  d = preset;
            OP_COUNT: d = incr;
            default:  d = q;
        endcase
    end

endmodule

// File: rtl/progctr_reg.sv
// Module: progctr_reg
// State register. ASYNC_CLR picks whether clr_n zeroes the state at once
// or only through the synchronous next-state path.
// Assumes: d already carries the clear value when clr_n is low.
module progctr_reg #(
    parameter int WIDTH     = 4,
    parameter bit ASYNC_CLR = 1'b1
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        if (ASYNC_CLR) begin : g_async
            // Register with an immediate active-low clear.
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n)
                    q <= '0;
                else
                    q <= d;
            end
        end else begin : g_sync
            // Register cleared only at the clock edge.
            always_ff @(posedge clk) begin
                if (!clr_n)
                    q <= '0;
                else
                    q <= d;
            end
        end
    endgenerate

endmodule

// File: rtl/progctr_tc.sv
// Module: progctr_tc
// Terminal-count detection and carry gating for cascading.
// Assumes: carry must be combinational so that the next stage sees it
// before the same edge.
module progctr_tc
    import progctr_pkg::*;
#(
    parameter int WIDTH  = 4,
    parameter bit DECADE = 1'b0
) (
    input  logic [WIDTH-1:0] q,
    input  logic             en_t,
    output logic             carry
);

    localparam logic [WIDTH-1:0] TERM = WIDTH'(term_value(WIDTH, DECADE));

    // Carry is high on the terminal value, gated by the trickle enable.
    always_comb begin
        carry = en_t && (q == TERM);
    end

endmodule

// File: rtl/progctr4.sv
// Module: progctr4
// Cascadable programmable up-counter. DECADE picks modulo 10 instead of
// modulo 2**WIDTH. ASYNC_CLR picks an immediate clear instead of a
// clock-edge clear.
// Assumes: clr_n is the only reset. The enables may change at any time
// and are sampled only at the rising edge.
module progctr4
    import progctr_pkg::*;
#(
    parameter int WIDTH     = 4,
    parameter bit DECADE    = 1'b0,
    parameter bit ASYNC_CLR = 1'b1
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             ld_n,
    input  logic [WIDTH-1:0] preset,
    input  logic             en_p,
    input  logic             en_t,
    output logic [WIDTH-1:0] q,
    output logic             carry
);

    ctr_op_e          op;
    logic [WIDTH-1:0] d;

    progctr_ctl u_ctl (
        .clr_n (clr_n),
        .ld_n  (ld_n),
        .en_p  (en_p),
        .en_t  (en_t),
        .op    (op)
    );

    progctr_next #(.WIDTH(WIDTH), .DECADE(DECADE)) u_next (
        .op     (op),
        .q      (q),
        .preset (preset),
        .d      (d)
    );

    progctr_reg #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_reg (
        .clk   (clk),
        .clr_n (clr_n),
        .d     (d),
        .q     (q)
    );

    progctr_tc #(.WIDTH(WIDTH), .DECADE(DECADE)) u_tc (
        .q     (q),
        .en_t  (en_t),
        .carry (carry)
    );

endmodule

// File: rtl/progctr4_chk.sv
// Module: progctr4_chk
// Assertion checker for progctr4, attached with bind.
module progctr4_chk
    import progctr_pkg::*;
#(
    parameter int WIDTH     = 4,
    parameter bit DECADE    = 1'b0,
    parameter bit ASYNC_CLR = 1'b1
) (
    input logic             clk,
    input logic             clr_n,
    input logic             ld_n,
    input logic [WIDTH-1:0] preset,
    input logic             en_p,
    input logic             en_t,
    input logic [WIDTH-1:0] q,
    input logic             carry
);

    localparam logic [WIDTH-1:0] TERM = WIDTH'(term_value(WIDTH, DECADE));

    // R3 (R1, R2): a clear seen at an edge leaves zero by the next edge.
    // No disable here, because the clear is the reset itself.
    clear_zero_chk: assert property (@(posedge clk)
        !clr_n |=> q == '0);

    // R4
    load_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !ld_n |=> q == $past(preset));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (ld_n && !(en_p && en_t)) |=> $stable(q));

    // R5
    count_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (ld_n && en_p && en_t && q != TERM) |=> q == $past(q) + WIDTH'(1));

    // R6 R7
    wrap_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (ld_n && en_p && en_t && q == TERM) |=> q == '0);

    // R9
    carry_gate_chk: assert property (@(posedge clk) disable iff (!clr_n)
        carry |-> (en_t && q == TERM));

endmodule

bind progctr4 progctr4_chk #(
    .WIDTH(WIDTH), .DECADE(DECADE), .ASYNC_CLR(ASYNC_CLR)
) u_chk (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .preset(preset),
    .en_p(en_p), .en_t(en_t), .q(q), .carry(carry)
);

// File: tb/sim_progctr4.sv
`timescale 1ns/1ps
// Directed bench. u0 is binary with an asynchronous clear, u_dec is decade
// with a synchronous clear, and u_c is a chain of three binary stages.
module sim_progctr4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       clr_n = 1'b0;
    logic       ld_n  = 1'b1;
    logic [3:0] preset = 4'd0;
    logic       en_p = 1'b0;
    logic       en_t = 1'b0;
    logic [3:0] q0, qd;
    logic       c0, cd;

    int checks = 0;
    int fails  = 0;

    progctr4 #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b1)) u0 (
        .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .preset(preset),
        .en_p(en_p), .en_t(en_t), .q(q0), .carry(c0));

    progctr4 #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLR(1'b0)) u_dec (
        .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .preset(preset),
        .en_p(en_p), .en_t(en_t), .q(qd), .carry(cd));

    // Cascade of three binary stages with synchronous clear.
    logic        c_clr_n = 1'b0;
    logic        c_ld_n  = 1'b1;
    logic [11:0] c_preset = 12'd0;
    logic        c_run = 1'b0;
    logic [3:0]  c_q [3];
    logic        c_carry [3];
    logic        tchain [4];

    assign tchain[0] = c_run;
    for (genvar g = 0; g < 3; g++) begin : g_chain
        assign tchain[g+1] = c_carry[g];
        progctr4 #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) u_c (
            .clk(clk), .clr_n(c_clr_n), .ld_n(c_ld_n),
            .preset(c_preset[g*4 +: 4]), .en_p(c_run), .en_t(tchain[g]),
            .q(c_q[g]), .carry(c_carry[g]));
    end

    // Compare one value and report a failure.
    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Wait for the next rising edge and move 1 ns past it.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Load a value into u0 and u_dec with the enables low.
    task automatic load_both(input logic [3:0] v);
        ld_n = 1'b0; preset = v; en_p = 1'b0; en_t = 1'b0;
        step();
        ld_n = 1'b1;
    endtask

    // Reset state of both counters.
    task automatic t_reset();
        step(); step();
        check("R1 reset q0", q0, 0);
        check("R2 reset qd", qd, 0);
        check("R9 reset carry", c0, 0);
        clr_n = 1'b1;
        step();
    endtask

    // Clear in the middle of a cycle, and clear over load and count.
    task automatic t_clear();
        load_both(4'd5);
        check("R4 load 5", q0, 5);
        clr_n = 1'b0;
        #1;
        check("R1 async clear at once", q0, 0);
        check("R2 sync clear waits", qd, 5);
        step();
        check("R2 sync clear at edge", qd, 0);
        load_both(4'd0);
        clr_n = 1'b1;
        load_both(4'd6);
        clr_n = 1'b0; ld_n = 1'b0; preset = 4'd9; en_p = 1'b1; en_t = 1'b1;
        step();
        check("R3 clear beats load q0", q0, 0);
        check("R3 clear beats load qd", qd, 0);
        clr_n = 1'b1; ld_n = 1'b1; en_p = 1'b0; en_t = 1'b0;
        step();
    endtask

    // Load ignores the enables, and counting needs both enables.
    task automatic t_load_enable();
        ld_n = 1'b0; preset = 4'd3; en_p = 1'b1; en_t = 1'b1;
        step();
        check("R4 load with enables high", q0, 3);
        ld_n = 1'b1; en_p = 1'b1; en_t = 1'b0;
        step();
        check("R5 en_p only holds", q0, 3);
        en_p = 1'b0; en_t = 1'b1;
        step();
        check("R5 en_t only holds", q0, 3);
        en_t = 1'b0;
        step();
        check("R5 no enable holds", q0, 3);
        en_p = 1'b1; en_t = 1'b1;
        step();
        check("R5 both enables count", q0, 4);
        check("R5 decade counts too", qd, 4);
        en_p = 1'b0; en_t = 1'b0;
    endtask

    // Binary wrap and carry gating by en_t.
    task automatic t_binary_wrap();
        load_both(4'd14);
        en_p = 1'b1; en_t = 1'b1;
        step();
        check("R5 count to 15", q0, 15);
        check("R9 carry at 15", c0, 1);
        en_t = 1'b0;
        #1;
        check("R9 carry drops with en_t", c0, 0);
        en_t = 1'b1;
        #1;
        check("R9 carry returns with en_t", c0, 1);
        step();
        check("R6 binary wrap 15 to 0", q0, 0);
        check("R9 no carry at 0", c0, 0);
        en_p = 1'b0; en_t = 1'b0;
    endtask

    // Decade wrap, and counting from values above 9.
    task automatic t_decade();
        load_both(4'd8);
        en_p = 1'b1; en_t = 1'b1;
        step();
        check("R7 decade at 9", qd, 9);
        check("R9 decade carry at 9", cd, 1);
        check("R9 binary no carry at 9", c0, 0);
        step();
        check("R7 decade wrap 9 to 0", qd, 0);
        check("R6 binary passes 9", q0, 10);
        load_both(4'd12);
        en_p = 1'b1; en_t = 1'b1;
        for (int v = 13; v <= 15; v++) begin
            #0.5;
            check("R8 no carry above 9", cd, 0);
            step();
            check("R8 decade counts above 9", qd, v);
        end
        check("R8 no carry at 15", cd, 0);
        step();
        check("R8 decade 15 to 0", qd, 0);
        en_p = 1'b0; en_t = 1'b0;
    endtask

    // Three stages counting as one 12-bit counter through 0xFFF.
    task automatic t_cascade();
        int exp;
        c_clr_n = 1'b1;
        c_ld_n = 1'b0; c_preset = 12'hFF0;
        step();
        c_ld_n = 1'b1;
        exp = 12'hFF0;
        check("R10 chain load", {c_q[2], c_q[1], c_q[0]}, exp);
        c_run = 1'b1;
        for (int i = 0; i < 20; i++) begin
            if (exp == 12'hFFF) begin
                check("R10 top carry at all ones", c_carry[2], 1);
            end
            step();
            exp = (exp + 1) & 12'hFFF;
            check("R10 chain count", {c_q[2], c_q[1], c_q[0]}, exp);
        end
        c_run = 1'b0;
        step(); step();
        check("R10 chain holds", {c_q[2], c_q[1], c_q[0]}, exp);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 5);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_clear();
        t_load_enable();
        t_binary_wrap();
        t_decade();
        t_cascade();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule